// File: doc/BRIEF.md
# Gray-Qualified Word Crossing Between Unrelated Clocks

This block carries one multi-bit data word at a time from a source clock domain into a destination clock domain whose clock has no known relation to the source clock. The data bits are never synchronized individually. The source side captures the word into a holding register and keeps it frozen. It then steps a small Gray-coded request counter. Only that counter crosses, through a chain of synchronizer flops. The destination side compares the synchronized counter with the last value it acted on. When they differ, it copies the frozen word and raises a one-cycle valid pulse.

The destination returns the counter value it has consumed as a Gray-coded acknowledge. That value crosses back through its own synchronizer chain. The source accepts no new word until the acknowledge matches its request code. The block is therefore meant for low transfer rates: each word costs a full round trip through both synchronizers. Each domain has its own active-low reset. Assertion of that reset is asynchronous, and a local two-flop stage releases it synchronously.

Top module: `gray_handshake_xfer`

## Requirements
- R1: While both resets are applied and right after they are released, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A word is accepted on a rising `src_clk` edge where `src_valid` and `src_ready` are both 1. From the following cycle, `src_ready` is 0.
- R3: While `src_ready` is 0, the values on `src_valid` and `src_data` have no effect. No extra transfer occurs and the word being delivered is unchanged.
- R4: Every accepted word produces exactly one `dst_valid` pulse, and each pulse is one `dst_clk` cycle wide. The crossing codes change by at most one bit per clock.
- R5: During the pulse, `dst_data` equals the accepted word. It keeps that value until the next pulse.
- R6: `dst_valid` is high no later than the (SYNC_STAGES+2)-th rising `dst_clk` edge after the accepting `src_clk` edge.
- R7: `src_ready` returns to 1 only after the corresponding `dst_valid` pulse has occurred. It returns within a bounded number of `src_clk` cycles.
- R8: Transfers continue correctly across the wrap of the 2^CODE_W-value request counter, and after a later reset of both domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Source side can take a word |
| src_data | input | DATA_W | Word to transfer |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_valid | output | 1 | One-cycle pulse: a new word is on dst_data |
| dst_data | output | DATA_W | Last word delivered |

## Verification
The source handshake is exact. `src_ready` must read 0 half a source cycle after the accepting edge, so the bench samples it at the next falling `src_clk` edge. The destination pulse depends on the phase between the two clocks. The bench therefore waits for it at falling `dst_clk` edges, inside a window a little wider than the three-edge register path (two synchronizer flops plus the valid flop), and fails the check if the window closes. The return of `src_ready` runs through two source synchronizer flops and the state flop. The bench allows a fixed source-cycle window for it, and a monitor confirms that it never returns before the destination pulse has been seen.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int unsigned GX_DATA_W      = 16;
  localparam int unsigned GX_CODE_W      = 2;
  localparam int unsigned GX_SYNC_STAGES = 2;

  // Source side occupancy: idle accepts a word, busy waits for the acknowledge.
  typedef enum logic {
    SRC_IDLE = 1'b0,
    SRC_BUSY = 1'b1
  } src_state_e;
endpackage

// File: rtl/gx_rst_sync.sv
// Asynchronous assertion, synchronous release of a domain reset.
module gx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gx_sync.sv
// Multi-flop synchronizer for a Gray-coded bus; the input must come straight from a register.
module gx_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q[0] <= '0;
    end else begin
      stage_q[0] <= async_i;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gx_src_side.sv
module gx_src_side
  import gx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CODE_W-1:0] ack_sync_i,
  output logic [CODE_W-1:0] req_gray_o,
  output logic [DATA_W-1:0] hold_o
);
  src_state_e        state_q, state_d;
  logic [CODE_W-1:0] bin_q, bin_d;
  logic [CODE_W-1:0] gray_q, gray_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              accept;
  logic              acked;

  assign accept = (state_q == SRC_IDLE) && valid_i;
  assign acked  = (ack_sync_i == gray_q);

  always_comb begin
    state_d = state_q;
    bin_d   = bin_q;
    gray_d  = gray_q;
    hold_d  = hold_q;
    unique case (state_q)
      SRC_IDLE: begin
        if (accept) begin
          bin_d   = bin_q + 1'b1;
          gray_d  = bin_d ^ (bin_d >> 1);
          hold_d  = data_i;
          state_d = SRC_BUSY;
        end
      end
      SRC_BUSY: begin
        if (acked) begin
          state_d = SRC_IDLE;
        end
      end
      default: state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_IDLE;
      bin_q   <= '0;
      gray_q  <= '0;
    end else begin
      state_q <= state_d;
      bin_q   <= bin_d;
      gray_q  <= gray_d;
    end
  end

  // Holding register: written only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (accept) begin
      hold_q <= hold_d;
    end
  end

  assign ready_o    = (state_q == SRC_IDLE);
  assign req_gray_o = gray_q;
  assign hold_o     = hold_q;
endmodule

// File: rtl/gx_dst_side.sv
module gx_dst_side #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] req_sync_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CODE_W-1:0] ack_gray_o
);
  logic [CODE_W-1:0] seen_q, seen_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              fresh;

  assign fresh = (req_sync_i != seen_q);

  always_comb begin
    seen_d  = seen_q;
    valid_d = 1'b0;
    data_d  = data_q;
    if (fresh) begin
      seen_d  = req_sync_i;
      valid_d = 1'b1;
      data_d  = hold_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (fresh) begin
      data_q <= data_d;
    end
  end

  assign valid_o    = valid_q;
  assign data_o     = data_q;
  assign ack_gray_o = seen_q;
endmodule

// File: rtl/gray_handshake_xfer.sv
module gray_handshake_xfer
  import gx_pkg::*;
#(
  parameter int unsigned DATA_W      = GX_DATA_W,
  parameter int unsigned CODE_W      = GX_CODE_W,
  parameter int unsigned SYNC_STAGES = GX_SYNC_STAGES
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  logic              src_rst_n_int;
  logic              dst_rst_n_int;
  logic [CODE_W-1:0] req_gray;
  logic [CODE_W-1:0] req_sync;
  logic [CODE_W-1:0] ack_gray;
  logic [CODE_W-1:0] ack_sync;
  logic [DATA_W-1:0] hold_word;

  gx_rst_sync #(.STAGES(2)) u_rs_src (
    .clk(src_clk), .rst_n_i(src_rst_n), .rst_n_o(src_rst_n_int)
  );

  gx_rst_sync #(.STAGES(2)) u_rs_dst (
    .clk(dst_clk), .rst_n_i(dst_rst_n), .rst_n_o(dst_rst_n_int)
  );

  gx_src_side #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_src (
    .clk        (src_clk),
    .rst_n      (src_rst_n_int),
    .valid_i    (src_valid),
    .ready_o    (src_ready),
    .data_i     (src_data),
    .ack_sync_i (ack_sync),
    .req_gray_o (req_gray),
    .hold_o     (hold_word)
  );

  gx_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n_int), .async_i(req_gray), .sync_o(req_sync)
  );

  gx_dst_side #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_dst (
    .clk        (dst_clk),
    .rst_n      (dst_rst_n_int),
    .req_sync_i (req_sync),
    .hold_i     (hold_word),
    .valid_o    (dst_valid),
    .data_o     (dst_data),
    .ack_gray_o (ack_gray)
  );

  gx_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n_int), .async_i(ack_gray), .sync_o(ack_sync)
  );
endmodule

// File: rtl/gx_xfer_chk.sv
module gx_xfer_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CODE_W = 2
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              src_valid,
  input logic              src_ready,
  input logic              dst_valid,
  input logic [DATA_W-1:0] dst_data,
  input logic [DATA_W-1:0] hold_word,
  input logic [CODE_W-1:0] req_gray,
  input logic [CODE_W-1:0] ack_gray
);
  // R2: after acceptance the source side stops offering readiness
  a_r2_ready_drops: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_valid && src_ready) |=> !src_ready);

  // R3: the holding register moves only on an accepting edge
  a_r3_hold_frozen: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !$stable(hold_word) |-> $past(src_valid && src_ready));

  // R4: pulse is one destination cycle wide
  a_r4_single_pulse: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> !dst_valid);

  // R4: request code moves by at most one bit
  a_r4_req_gray_step: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $countones(req_gray ^ $past(req_gray)) <= 1);

  // R4: acknowledge code moves by at most one bit
  a_r4_ack_gray_step: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $countones(ack_gray ^ $past(ack_gray)) <= 1);

  // R5: delivered word changes only together with a pulse
  a_r5_data_with_pulse: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !$stable(dst_data) |-> dst_valid);
endmodule

bind gray_handshake_xfer gx_xfer_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .src_clk   (src_clk),
  .src_rst_n (src_rst_n_int),
  .dst_clk   (dst_clk),
  .dst_rst_n (dst_rst_n_int),
  .src_valid (src_valid),
  .src_ready (src_ready),
  .dst_valid (dst_valid),
  .dst_data  (dst_data),
  .hold_word (hold_word),
  .req_gray  (req_gray),
  .ack_gray  (ack_gray)
);

// File: tb/gray_handshake_xfer_bench.sv
module gray_handshake_xfer_bench;
  localparam int unsigned DW = 16;
  localparam int unsigned NV = 10;
  // {gap cycles before offer [7:0], word [15:0]}
  localparam logic [23:0] VEC [NV] = '{
    {8'd0, 16'h0000}, {8'd1, 16'hFFFF}, {8'd0, 16'hA5A5}, {8'd3, 16'h5A5A},
    {8'd0, 16'h0001}, {8'd2, 16'h8000}, {8'd0, 16'h1234}, {8'd5, 16'hFEDC},
    {8'd0, 16'h0F0F}, {8'd1, 16'hC3C3}
  };

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          src_rst_n = 1'b0;
  logic          dst_rst_n = 1'b0;
  logic          src_valid = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          src_ready;
  logic          dst_valid;
  logic [DW-1:0] dst_data;

  int n_checks = 0;
  int n_fail   = 0;
  int tx_cnt   = 0;
  int rx_cnt   = 0;
  logic [DW-1:0] last_rx = '0;
  logic prev_dvalid = 1'b0;
  logic prev_ready  = 1'b1;

  always #10 src_clk = ~src_clk;
  always #7  dst_clk = ~dst_clk;

  gray_handshake_xfer u_gray_handshake_xfer (
    .src_clk, .src_rst_n, .src_valid, .src_ready, .src_data,
    .dst_clk, .dst_rst_n, .dst_valid, .dst_data
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Destination monitor: pulse width (R4) and data hold (R5)
  always @(negedge dst_clk) begin
    if (!dst_rst_n) begin
      last_rx     = '0;
      prev_dvalid = 1'b0;
    end else begin
      if (dst_valid) begin
        if (prev_dvalid) chk(1'b0, "R4", "pulse wider than one cycle", 32'd2, 32'd1);
        last_rx = dst_data;
        rx_cnt++;
      end else if (dst_data != last_rx) begin
        chk(1'b0, "R5", "dst_data moved without pulse", dst_data, last_rx);
      end
      prev_dvalid = dst_valid;
    end
  end

  // Source monitor: readiness returns only after delivery (R7)
  always @(negedge src_clk) begin
    if (src_ready && !prev_ready)
      chk(rx_cnt == tx_cnt, "R7", "ready back before delivery", rx_cnt, tx_cnt);
    prev_ready = src_ready;
  end

  task automatic do_reset();
    src_rst_n = 1'b0; dst_rst_n = 1'b0; src_valid = 1'b0;
    repeat (3) @(negedge src_clk);
    chk(src_ready == 1'b1, "R1", "ready in reset", src_ready, 1);
    chk(dst_valid == 1'b0, "R1", "valid in reset", dst_valid, 0);
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    repeat (4) @(negedge src_clk);
    chk(src_ready == 1'b1, "R1", "ready after reset", src_ready, 1);
    chk(dst_valid == 1'b0, "R1", "valid after reset", dst_valid, 0);
    chk(dst_data == '0, "R1", "data after reset", dst_data, 0);
  endtask

  task automatic send(input logic [DW-1:0] word, input int gap, input int hold_extra,
                      input logic [DW-1:0] junk);
    int n;
    repeat (gap) @(negedge src_clk);
    n = 0;
    while (!src_ready && n < 20) begin @(negedge src_clk); n++; end
    src_valid = 1'b1; src_data = word;
    @(negedge src_clk);
    tx_cnt++;
    chk(src_ready == 1'b0, "R2", "ready after accept", src_ready, 0);
    // R3: keep offering a different word while busy
    src_data = junk;
    for (int k = 0; k < hold_extra; k++) begin
      @(negedge src_clk);
      chk(src_ready == 1'b0, "R3", "ready while busy", src_ready, 0);
    end
    src_valid = 1'b0;
    n = 0;
    while (rx_cnt != tx_cnt && n < 6) begin @(negedge dst_clk); n++; end
    chk(rx_cnt == tx_cnt, "R6", "pulse latency", rx_cnt, tx_cnt);
    chk(last_rx == word, "R5", "delivered word", last_rx, word);
    n = 0;
    while (!src_ready && n < 10) begin @(negedge src_clk); n++; end
    chk(src_ready == 1'b1, "R7", "ready return", src_ready, 1);
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // Table walk; ten words pass the four-value counter wrap twice (R8)
    for (int i = 0; i < int'(NV); i++) begin
      send(VEC[i][15:0], int'(VEC[i][23:16]), 0, '0);
    end
    chk(rx_cnt == int'(NV), "R8", "transfers across wrap", rx_cnt, NV);
    // R3: offer ignored while busy, no extra pulse
    send(16'hBEEF, 0, 2, 16'hDEAD);
    repeat (15) @(negedge src_clk);
    chk(rx_cnt == tx_cnt, "R3", "no extra transfer", rx_cnt, tx_cnt);
    chk(dst_data == 16'hBEEF, "R3", "word unchanged", dst_data, 16'hBEEF);
    // R8: second reset, then the link works again
    do_reset();
    send(16'h7E57, 1, 0, '0);
    chk(dst_data == 16'h7E57, "R8", "transfer after reset", dst_data, 16'h7E57);
    repeat (4) @(negedge src_clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule